// File: doc/BRIEF.md
# Multi-Channel Event Timestamp Capture

This block keeps three capture registers that each copy a free-running time value when an event they watch takes place. Two kinds of event exist: a one-cycle strobe that marks a change of power source, and an edge on an external timestamp pin. Each channel is set up on its own to follow the strobe, the pin, or both. On a capture the channel raises a sticky flag, and can raise an interrupt request from it.

A channel works in one of two modes. In keep-first mode the channel holds its value while its flag is up, so the earliest event since the last clear survives. In keep-latest mode it takes every event. Software sets up the channels through a small register port, reads back the captured values and the flags, and clears flags by writing ones. Time keeping and the serial host bus are outside this block.

Top module: `evts_capture_top`

## Requirements
- R1: After reset every channel setup register, the pin polarity register, all flags, all captured values and `irq_o` read as zero.
- R2: Channel i's setup register is at address i (0..2). Its bits are: bit0 strobe enable, bit1 pin enable, bit2 keep-latest mode, bit3 interrupt enable. When bit0 is set and the strobe is high at a clock edge, the channel captures `time_i` from that edge and sets its flag.
- R3: The pin passes through a two-flip-flop synchroniser. Address 3 bit0 selects the active edge: 1 for rising, 0 for falling. A pin change that arrives before edge k is captured at edge k+2, using the `time_i` value at edge k+2. The inactive edge captures nothing.
- R4: A channel with both enables set captures on either event. A source whose enable is clear changes neither the flag nor the captured value.
- R5: In keep-first mode (bit2 = 0) an event leaves the captured value and the flag unchanged while the flag is set.
- R6: In keep-latest mode (bit2 = 1) every accepted event overwrites the captured value, and the flag stays set.
- R7: Writing to address 4 clears the flag of every channel whose bit (bit i for channel i) is 1. A 0 bit leaves that flag alone. Reading address 4 returns the flags in the same bit positions.
- R8: When a capture and a clear of the same channel happen at the same edge, the capture wins and the flag stays set.
- R9: `irq_o` is high exactly when at least one channel has both its flag and its interrupt enable set.
- R10: Addresses 5, 6 and 7 read the captured values of channels 0, 1 and 2. Setup registers read back the value last written, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_i | input | 32 | Current time value |
| swo_i | input | 1 | Power-source change strobe, one cycle |
| ts_pin_i | input | 1 | Timestamp pin, asynchronous |
| addr_i | input | 3 | Register address for read and write |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 4 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is an event arriving at the same edge as a flag clear, on a channel whose flag is already set, in each mode. In keep-first mode the clear must win because the event is refused. In keep-latest mode the capture must win. The bench gets there by sweeping all sixteen setup codes across the three channels with staggered offsets, for both pin polarities. Each sweep step leaves the flags in a mix of states and then fires a strobe together with a write of all-ones to the flag register. A reference model in the bench, which tracks the pin delay on its own, predicts every flag and captured value.

// File: rtl/evts_pkg.sv
package evts_pkg;

  localparam int CFG_W = 4;

  // channel setup word, bit0 at the bottom
  typedef struct packed {
    logic irq_en;     // bit3
    logic last_mode;  // bit2
    logic pin_en;     // bit1
    logic swo_en;     // bit0
  } ch_cfg_t;

  // edge of the synchronised pin in the selected direction
  function automatic logic edge_hit(input logic cur, input logic prev, input logic rising);
    return rising ? (cur & ~prev) : (~cur & prev);
  endfunction

  // channel sees one of its enabled sources
  function automatic logic chan_trig(input ch_cfg_t c, input logic swo, input logic pin_ev);
    return (c.swo_en & swo) | (c.pin_en & pin_ev);
  endfunction

  // channel accepts the trigger: keep-latest always, keep-first only while flag is clear
  function automatic logic chan_take(input ch_cfg_t c, input logic trig, input logic flag);
    return trig & (c.last_mode | ~flag);
  endfunction

endpackage

// File: rtl/evts_pin_sync.sv
module evts_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rising_i,
  output logic edge_o
);
  import evts_pkg::*;

  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign edge_o = edge_hit(s2_q, s3_q, rising_i);

  // R3
  edge_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !(edge_o && $stable(rising_i)));

endmodule

// File: rtl/evts_channel.sv
module evts_channel #(
  parameter int TIME_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  evts_pkg::ch_cfg_t   cfg_i,
  input  logic                swo_i,
  input  logic                pin_ev_i,
  input  logic                clr_i,
  input  logic [TIME_W-1:0]   time_i,
  output logic                flag_o,
  output logic [TIME_W-1:0]   stamp_o,
  output logic                irq_o,
  output logic                cap_o
);
  import evts_pkg::*;

  logic              trig;
  logic              flag_q;
  logic [TIME_W-1:0] stamp_q;

  assign trig  = chan_trig(cfg_i, swo_i, pin_ev_i);
  assign cap_o = chan_take(cfg_i, trig, flag_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      stamp_q <= '0;
    end else if (cap_o) begin
      flag_q  <= 1'b1;
      stamp_q <= time_i;
    end else if (clr_i) begin
      flag_q  <= 1'b0;
    end
  end

  assign flag_o  = flag_q;
  assign stamp_o = stamp_q;
  assign irq_o   = flag_q & cfg_i.irq_en;

  // R2
  cap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |=> (flag_q && stamp_q == $past(time_i)));

  // R5
  first_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !cfg_i.last_mode) |=> ($stable(stamp_q) && flag_q || !flag_q && $past(clr_i)));

  // R7
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !cap_o) |=> !flag_q);

  // R8
  capture_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && cap_o) |=> flag_q);

endmodule

// File: rtl/evts_capture_top.sv
module evts_capture_top #(
  parameter int  NCH    = 3,
  parameter int  TIME_W = 32,
  localparam int ADDR_W = $clog2(2 * NCH + 2),
  localparam int WR_W   = (evts_pkg::CFG_W > NCH) ? evts_pkg::CFG_W : NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_i,
  input  logic              swo_i,
  input  logic              ts_pin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [WR_W-1:0]   wr_data_i,
  output logic [TIME_W-1:0] rd_data_o,
  output logic              irq_o
);
  import evts_pkg::*;

  localparam int CFG_BASE   = 0;
  localparam int POL_ADDR   = NCH;
  localparam int FLAG_ADDR  = NCH + 1;
  localparam int STAMP_BASE = NCH + 2;

  ch_cfg_t           cfg_q   [NCH];
  logic              rising_q;
  logic              pin_ev;
  logic [NCH-1:0]    clr_vec;
  logic [NCH-1:0]    flags;
  logic [NCH-1:0]    irq_vec;
  logic [NCH-1:0]    cap_vec;
  logic [TIME_W-1:0] stamps  [NCH];

  evts_pin_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (ts_pin_i),
    .rising_i (rising_q),
    .edge_o   (pin_ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rising_q <= 1'b0;
    end else if (wr_en_i && addr_i == ADDR_W'(POL_ADDR)) begin
      rising_q <= wr_data_i[0];
    end
  end

  assign clr_vec = (wr_en_i && addr_i == ADDR_W'(FLAG_ADDR)) ? wr_data_i[NCH-1:0] : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
      end else if (wr_en_i && addr_i == ADDR_W'(CFG_BASE + g)) begin
        cfg_q[g] <= ch_cfg_t'(wr_data_i[CFG_W-1:0]);
      end
    end

    evts_channel #(.TIME_W(TIME_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_i    (cfg_q[g]),
      .swo_i    (swo_i),
      .pin_ev_i (pin_ev),
      .clr_i    (clr_vec[g]),
      .time_i   (time_i),
      .flag_o   (flags[g]),
      .stamp_o  (stamps[g]),
      .irq_o    (irq_vec[g]),
      .cap_o    (cap_vec[g])
    );
  end

  assign irq_o = |irq_vec;

  always_comb begin
    rd_data_o = '0;
    if (addr_i == ADDR_W'(POL_ADDR)) rd_data_o[0] = rising_q;
    if (addr_i == ADDR_W'(FLAG_ADDR)) rd_data_o[NCH-1:0] = flags;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == ADDR_W'(CFG_BASE + i))   rd_data_o[CFG_W-1:0] = cfg_q[i];
      if (addr_i == ADDR_W'(STAMP_BASE + i)) rd_data_o = stamps[i];
    end
  end

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|flags));

  // R7
  flag_rise_needs_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~$past(flags) & flags)) |-> (|$past(cap_vec)));

endmodule

// File: tb/sim_evts_capture_top.sv
module sim_evts_capture_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] time_i = '0;
  logic        swo_i = 1'b0;
  logic        ts_pin_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  always #2.5 clk = ~clk;   // 200 MHz

  evts_capture_top u0 (
    .clk(clk), .rst_n(rst_n), .time_i(time_i), .swo_i(swo_i),
    .ts_pin_i(ts_pin_i), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] tnow = 32'd100;
  logic [3:0]  m_cfg [3];
  logic        m_pol;
  logic        m_flag[3];
  logic [31:0] m_st  [3];
  logic        pin_lvl;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // advance one cycle; drive defaults just after the falling edge
  task automatic tick();
    @(negedge clk);
    tnow = tnow + 32'd13;
    time_i = tnow;
    swo_i = 1'b0;
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    tick();
    addr_i = a;
    #1;
    v = rd_data_o;
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] d);
    tick();
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
  endtask

  // reference model of one edge
  task automatic model(input bit is_swo, input bit is_pin, input logic [2:0] clr, input logic [31:0] t);
    for (int c = 0; c < 3; c++) begin
      bit trig, acc;
      trig = (m_cfg[c][0] && is_swo) || (m_cfg[c][1] && is_pin);
      acc  = trig && (m_cfg[c][2] || !m_flag[c]);
      if (acc) begin m_flag[c] = 1'b1; m_st[c] = t; end
      else if (clr[c]) m_flag[c] = 1'b0;
    end
  endtask

  task automatic check_all(input string what);
    logic [31:0] v;
    logic exp_irq;
    rd(3'd4, v);
    chk({"R7 flags ", what}, v, {29'd0, m_flag[2], m_flag[1], m_flag[0]});
    for (int c = 0; c < 3; c++) begin
      rd(3'(5 + c), v);
      chk({"R10 stamp ", what}, v, m_st[c]);
    end
    exp_irq = 1'b0;
    for (int c = 0; c < 3; c++) exp_irq |= m_flag[c] & m_cfg[c][3];
    chk({"R9 irq ", what}, {31'd0, irq_o}, {31'd0, exp_irq});
  endtask

  task automatic strobe(input logic [2:0] clr);
    tick();
    swo_i = 1'b1;
    if (clr != 0) begin addr_i = 3'd4; wr_data_i = {1'b0, clr}; wr_en_i = 1'b1; end
    model(1, 0, clr, tnow);
  endtask

  task automatic pin_to(input logic v);
    bit hit;
    hit = (v != pin_lvl) && (v == m_pol);
    tick(); ts_pin_i = v;
    tick(); tick();
    model(0, hit, 3'd0, tnow);   // capture lands two edges after the synchroniser input
    tick();
    pin_lvl = v;
  endtask

  initial begin
    logic [31:0] v;
    for (int c = 0; c < 3; c++) begin m_cfg[c] = '0; m_flag[c] = 0; m_st[c] = '0; end
    m_pol = 0; pin_lvl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R1 reset readback", v, 32'd0);
    end
    chk("R1 reset irq", {31'd0, irq_o}, 32'd0);

    for (int p = 0; p < 2; p++) begin
      for (int code = 0; code < 16; code++) begin
        // quiet all channels, park pin on the inactive level (R4: disabled sources)
        for (int c = 0; c < 3; c++) begin wr(3'(c), 4'd0); m_cfg[c] = 4'd0; end
        pin_to(p[0] ? 1'b0 : 1'b1);
        pin_to(p[0] ? 1'b0 : 1'b1);
        wr(3'd3, {3'd0, p[0]}); m_pol = p[0];
        for (int c = 0; c < 3; c++) begin
          m_cfg[c] = 4'((code + 5 * c) % 16);
          wr(3'(c), m_cfg[c]);
        end
        // R10 setup readback
        for (int c = 0; c < 3; c++) begin
          rd(3'(c), v);
          chk("R10 cfg readback", v, {28'd0, m_cfg[c]});
        end
        rd(3'd3, v);
        chk("R3 polarity readback", v, {31'd0, m_pol});
        wr(3'd4, 4'h7); model(0, 0, 3'h7, tnow);
        check_all("after clear");
        strobe(3'd0);                 // R2 strobe capture
        check_all("strobe 1");
        pin_to(m_pol);                // R3 active edge, R4 either source
        check_all("active pin edge");
        strobe(3'd0);                 // R5 keep-first hold, R6 overwrite
        check_all("strobe 2");
        pin_to(~m_pol);               // R3 inactive edge ignored
        check_all("inactive pin edge");
        strobe(3'h7);                 // R8 capture vs clear at one edge
        check_all("strobe with clear");
        wr(3'd4, 4'(code % 8)); model(0, 0, 3'(code % 8), tnow);  // R7 masked clear
        check_all("masked clear");
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

endmodule